// File: doc/BRIEF.md
# Switch Output Fault Checker

This block runs on the controller side of a serial low-side switch. It confirms that the switch carried out a command word. One sequence writes the same command word twice over an SPI master link. The switch answers each word with the status of the word before it. The answer to the second write is therefore the status that the command produced. That answer is XOR-ed with the command. A zero result means the outputs match the request. Any bit that differs is reported in a fault mask. The answer to the first write is thrown away.

There are two kinds of check. A bus check repeats the word after a short gap, which confirms the serial path end to end. A load check waits a long gap before the repeat, so the switch has time to settle and sense its drains. Both gaps are counted in clock cycles and set by parameters. By default they derive from the clock rate: just over 100 µs for the long gap and 1 µs for the short one. The short gap is kept well inside the roughly 5 µs window a bus check needs.

In a command word a 0 bit requests that output ON. A returned status of all ones while the command asked for any output ON points to a global shutdown of the switch. That case is raised on its own flag. Finding the cause of a mismatch is left to software.

The control is one state machine:
- `S_IDLE` goes to `S_WORD1` on an accepted start.
- `S_WORD1` goes to `S_GAP` when the first transfer ends.
- `S_GAP` goes to `S_WORD2` when the gap timer expires.
- `S_WORD2` goes to `S_REPORT` when the second transfer ends.
- `S_REPORT` always returns to `S_IDLE` after one cycle.

Top module: `sw_fault_checker`

## Requirements
- R1: After reset, `cs_n`=1, `sclk`=0, `busy`=0, `done`=0, `pass`=0, `fault_mask`=0 and `shutdown`=0.
- R2: A `start` taken while idle produces exactly two SPI words, each framed by `cs_n` low.
  - Each word carries `cmd` MSB first.
  - `sclk` idles low, `mosi` changes on falling edges, and `miso` is sampled on rising edges.
- R3: With `mode_load`=0 (bus check), `cs_n` stays high for at least SHORT_GAP and at most SHORT_GAP+4 clock cycles between the two words.
- R4: With `mode_load`=1 (load check), `cs_n` stays high for at least LONG_GAP and at most LONG_GAP+4 clock cycles between the two words.
- R5: The status returned during the first word has no effect on any result.
- R6: `fault_mask` equals (second status XOR `cmd`), and `pass`=1 exactly when that mask is zero.
- R7: `shutdown`=1 exactly when the second status is all ones and `cmd` is not all ones. A command of all ones with an all-ones status gives `pass`=1 and `shutdown`=0.
- R8: `busy` is high from the cycle after an accepted `start` through the single cycle in which `done` pulses. `done` pulses exactly once per sequence.
- R9: A `start` raised while `busy` is high is ignored. This includes the `done` cycle. No further word is sent, and the results keep coming from the original command.
- R10: `fault_mask`, `pass` and `shutdown` hold their values from one `done` pulse until the next sequence's second word completes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Launch pulse, taken only while idle |
| cmd | input | WORD_W | Command word, 0 bit = output ON |
| mode_load | input | 1 | 1 = load check (long gap), 0 = bus check (short gap) |
| miso | input | 1 | Serial status from the switch |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle pulse when results are valid |
| pass | output | 1 | Second status matched the command |
| fault_mask | output | WORD_W | Second status XOR command |
| shutdown | output | 1 | All-ones status while some output was requested ON |
| cs_n | output | 1 | SPI chip select, active low |
| sclk | output | 1 | SPI clock, idle low |
| mosi | output | 1 | Serial command to the switch |

## Verification
A new `start` can coincide with the `done` cycle of the sequence that is finishing. At that point the machine is in `S_REPORT` and still busy. The bench raises `start` in exactly the cycle it sees `done`, carrying a different command. It then confirms that `cs_n` never falls again, that `busy` drops, and that no third word reaches the switch model. A second case raises `start` during the long gap. That case is judged by the word count, the words the switch model captured, and the mask, all of which must reflect only the original command.

// File: rtl/sfc_pkg.sv
package sfc_pkg;

    typedef enum logic [2:0] {
        S_IDLE   = 3'd0,
        S_WORD1  = 3'd1,
        S_GAP    = 3'd2,
        S_WORD2  = 3'd3,
        S_REPORT = 3'd4
    } sfc_state_e;

endpackage

// File: rtl/sfc_spi_xfer.sv
module sfc_spi_xfer #(
    parameter int WORD_W   = 8,
    parameter int SCLK_DIV = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic [WORD_W-1:0] tx,
    input  logic              miso,
    output logic [WORD_W-1:0] rx,
    output logic              done,
    output logic              cs_n,
    output logic              sclk,
    output logic              mosi
);
    localparam int DIV_W = (SCLK_DIV > 1) ? $clog2(SCLK_DIV) : 1;
    localparam int BIT_W = (WORD_W > 1) ? $clog2(WORD_W) : 1;

    logic              active;
    logic [DIV_W-1:0]  div_cnt;
    logic [BIT_W-1:0]  bit_cnt;
    logic [WORD_W-1:0] tx_sr;

    assign mosi = tx_sr[WORD_W-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            active  <= 1'b0;
            div_cnt <= '0;
            bit_cnt <= '0;
            tx_sr   <= '0;
            rx      <= '0;
            done    <= 1'b0;
            cs_n    <= 1'b1;
            sclk    <= 1'b0;
        end else begin
            done <= 1'b0;
            if (!active) begin
                if (go) begin
                    active  <= 1'b1;
                    cs_n    <= 1'b0;
                    sclk    <= 1'b0;
                    tx_sr   <= tx;
                    div_cnt <= '0;
                    bit_cnt <= '0;
                end
            end else if (div_cnt == DIV_W'(SCLK_DIV - 1)) begin
                div_cnt <= '0;
                if (!sclk) begin
                    sclk <= 1'b1;
                    rx   <= {rx[WORD_W-2:0], miso};
                end else begin
                    sclk <= 1'b0;
                    if (bit_cnt == BIT_W'(WORD_W - 1)) begin
                        active <= 1'b0;
                        cs_n   <= 1'b1;
                        done   <= 1'b1;
                    end else begin
                        bit_cnt <= bit_cnt + 1'b1;
                        tx_sr   <= {tx_sr[WORD_W-2:0], 1'b0};
                    end
                end
            end else begin
                div_cnt <= div_cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/sfc_gap_timer.sv
module sfc_gap_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] len,
    output logic             expired
);
    logic [CNT_W-1:0] remain;

    assign expired = (remain == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            remain <= '0;
        end else if (load) begin
            remain <= len;
        end else if (!expired) begin
            remain <= remain - 1'b1;
        end
    end
endmodule

// File: rtl/sw_fault_checker.sv
module sw_fault_checker
    import sfc_pkg::*;
#(
    parameter int CLK_HZ    = 250_000_000,
    parameter int WORD_W    = 8,
    parameter int SCLK_DIV  = 4,
    parameter int SHORT_GAP = CLK_HZ / 1_000_000,
    parameter int LONG_GAP  = CLK_HZ / 10_000 + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [WORD_W-1:0] cmd,
    input  logic              mode_load,
    input  logic              miso,
    output logic              busy,
    output logic              done,
    output logic              pass,
    output logic [WORD_W-1:0] fault_mask,
    output logic              shutdown,
    output logic              cs_n,
    output logic              sclk,
    output logic              mosi
);
    localparam int MAX_GAP = (LONG_GAP > SHORT_GAP) ? LONG_GAP : SHORT_GAP;
    localparam int CNT_W   = $clog2(MAX_GAP + 1);
    localparam logic [WORD_W-1:0] ALL_OFF = '1;

    sfc_state_e        state, state_nx;
    logic [WORD_W-1:0] cmd_q;
    logic              mode_q;
    logic              xfer_go, xfer_done, gap_load, gap_expired;
    logic [WORD_W-1:0] xfer_tx, xfer_rx;
    logic [CNT_W-1:0]  gap_len;

    assign xfer_go  = ((state == S_IDLE) && start) || ((state == S_GAP) && gap_expired);
    assign xfer_tx  = (state == S_IDLE) ? cmd : cmd_q;
    assign gap_load = (state == S_WORD1) && xfer_done;
    assign gap_len  = mode_q ? CNT_W'(LONG_GAP) : CNT_W'(SHORT_GAP);
    assign busy     = (state != S_IDLE);
    assign done     = (state == S_REPORT);

    sfc_spi_xfer #(.WORD_W(WORD_W), .SCLK_DIV(SCLK_DIV)) u_xfer (
        .clk  (clk),
        .rst_n(rst_n),
        .go   (xfer_go),
        .tx   (xfer_tx),
        .miso (miso),
        .rx   (xfer_rx),
        .done (xfer_done),
        .cs_n (cs_n),
        .sclk (sclk),
        .mosi (mosi)
    );

    sfc_gap_timer #(.CNT_W(CNT_W)) u_gap (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (gap_load),
        .len    (gap_len),
        .expired(gap_expired)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE:   if (start)       state_nx = S_WORD1;
            S_WORD1:  if (xfer_done)   state_nx = S_GAP;
            S_GAP:    if (gap_expired) state_nx = S_WORD2;
            S_WORD2:  if (xfer_done)   state_nx = S_REPORT;
            S_REPORT:                  state_nx = S_IDLE;
            default:                   state_nx = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_q      <= '0;
            mode_q     <= 1'b0;
            fault_mask <= '0;
            pass       <= 1'b0;
            shutdown   <= 1'b0;
        end else begin
            if ((state == S_IDLE) && start) begin
                cmd_q  <= cmd;
                mode_q <= mode_load;
            end
            if ((state == S_WORD2) && xfer_done) begin
                fault_mask <= xfer_rx ^ cmd_q;
                pass       <= (xfer_rx == cmd_q);
                shutdown   <= (xfer_rx == ALL_OFF) && (cmd_q != ALL_OFF);
            end
        end
    end
endmodule

// File: rtl/sfc_checker.sv
module sfc_checker #(
    parameter int WORD_W    = 8,
    parameter int SHORT_GAP = 1,
    parameter int LONG_GAP  = 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              mode_load,
    input logic              busy,
    input logic              done,
    input logic              pass,
    input logic [WORD_W-1:0] fault_mask,
    input logic              shutdown,
    input logic              cs_n,
    input logic              sclk
);
    logic        mode_seen;
    logic        cs_prev;
    logic [1:0]  rises;
    int unsigned hi_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_seen <= 1'b0;
            cs_prev   <= 1'b1;
            rises     <= '0;
            hi_cnt    <= 0;
        end else begin
            cs_prev <= cs_n;
            hi_cnt  <= cs_n ? hi_cnt + 1 : 0;
            if (start && !busy) begin
                mode_seen <= mode_load;
                rises     <= '0;
            end else if (cs_n && !cs_prev && rises != 2'd3) begin
                rises <= rises + 1'b1;
            end
        end
    end

    AST_RESET_IDLE:   assert property (@(posedge clk) disable iff (!rst_n) !busy |-> cs_n && !sclk && !done); // R1
    AST_SCLK_FRAMED:  assert property (@(posedge clk) disable iff (!rst_n) cs_n |-> !sclk); // R2
    AST_SHORT_GAP:    assert property (@(posedge clk) disable iff (!rst_n)
                          (cs_prev && !cs_n && rises == 2'd1 && !mode_seen) |-> hi_cnt >= 32'(SHORT_GAP)); // R3
    AST_LONG_GAP:     assert property (@(posedge clk) disable iff (!rst_n)
                          (cs_prev && !cs_n && rises == 2'd1 && mode_seen) |-> hi_cnt >= 32'(LONG_GAP)); // R4
    AST_PASS_MASK:    assert property (@(posedge clk) disable iff (!rst_n) done |-> (pass == (fault_mask == '0))); // R6
    AST_SHUT_FAILS:   assert property (@(posedge clk) disable iff (!rst_n) (done && shutdown) |-> !pass); // R7
    AST_DONE_BUSY:    assert property (@(posedge clk) disable iff (!rst_n) done |-> busy); // R8
    AST_DONE_PULSE:   assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R8
    AST_START_IGNORE: assert property (@(posedge clk) disable iff (!rst_n) done |=> cs_n && !busy); // R9
    AST_RESULT_HOLD:  assert property (@(posedge clk) disable iff (!rst_n)
                          !busy |=> $stable(fault_mask) && $stable(pass) && $stable(shutdown)); // R10
endmodule

bind sw_fault_checker sfc_checker #(
    .WORD_W   (WORD_W),
    .SHORT_GAP(SHORT_GAP),
    .LONG_GAP (LONG_GAP)
) u_sfc_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .mode_load (mode_load),
    .busy      (busy),
    .done      (done),
    .pass      (pass),
    .fault_mask(fault_mask),
    .shutdown  (shutdown),
    .cs_n      (cs_n),
    .sclk      (sclk)
);

// File: tb/sw_fault_checker_bench.sv
`timescale 1ns/1ps
module sw_fault_checker_bench;
    localparam int DIV = 2;
    localparam int SG  = 12;
    localparam int LG  = 300;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [7:0] cmd = 8'h00;
    logic       mode_load = 1'b0;
    logic       miso;
    logic       busy, done, pass, shutdown, cs_n, sclk, mosi;
    logic [7:0] fault_mask;

    always #2 clk = ~clk;

    sw_fault_checker #(
        .WORD_W(8), .SCLK_DIV(DIV), .SHORT_GAP(SG), .LONG_GAP(LG)
    ) u_sw_fault_checker (
        .clk(clk), .rst_n(rst_n), .start(start), .cmd(cmd), .mode_load(mode_load),
        .miso(miso), .busy(busy), .done(done), .pass(pass), .fault_mask(fault_mask),
        .shutdown(shutdown), .cs_n(cs_n), .sclk(sclk), .mosi(mosi)
    );

    // switch model, sampled on the falling clock edge
    logic [7:0] dev_junk = 8'h00;
    logic [7:0] dev_status = 8'h00;
    logic [7:0] out_sr = 8'h00;
    logic [7:0] rx_sr = 8'h00;
    logic [7:0] word_log [0:3];
    int         words = 0;
    int         hi = 0;
    int         meas_gap = 0;
    int         done_cnt = 0;
    logic       prev_cs = 1'b1;
    logic       prev_sclk = 1'b0;

    assign miso = out_sr[7];

    always @(negedge clk) begin
        if (prev_cs && !cs_n) begin
            if (words == 1) meas_gap = hi;
            out_sr = (words == 0) ? dev_junk : dev_status;
            words++;
        end
        if (!cs_n && prev_sclk && !sclk) out_sr = {out_sr[6:0], 1'b0};
        if (!cs_n && !prev_sclk && sclk) rx_sr = {rx_sr[6:0], mosi};
        if (!prev_cs && cs_n && words > 0 && words <= 4) word_log[words-1] = rx_sr;
        hi = cs_n ? hi + 1 : 0;
        if (done) done_cnt++;
        prev_cs   = cs_n;
        prev_sclk = sclk;
    end

    int tests = 0;
    int fails = 0;
    bit finished = 1'b0;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // {cmd, mode, fault, ov, junk}
    localparam int NV = 6;
    localparam logic [25:0] VEC [NV] = '{
        {8'hA5, 1'b0, 8'h00, 1'b0, 8'h5A},
        {8'h3C, 1'b1, 8'h00, 1'b0, 8'hFF},
        {8'h0F, 1'b1, 8'h81, 1'b0, 8'h0F},
        {8'h00, 1'b0, 8'hFF, 1'b0, 8'h00},
        {8'h7E, 1'b1, 8'h00, 1'b1, 8'h7E},
        {8'hFF, 1'b0, 8'h00, 1'b1, 8'h12}
    };

    task automatic run_seq(input logic [7:0] c, input logic m, input logic [7:0] flt,
                           input logic ov, input logic [7:0] junk,
                           input bit mid_start, input bit hit_done);
        logic [7:0] st;
        logic [7:0] exp_mask;
        int         lim;
        bit         seen;
        st       = ov ? 8'hFF : (c ^ flt);
        exp_mask = st ^ c;
        lim      = m ? LG : SG;
        while (busy) @(negedge clk);
        @(posedge clk);
        dev_junk = junk; dev_status = st;
        words = 0; done_cnt = 0; meas_gap = 0;
        @(negedge clk);
        start = 1'b1; cmd = c; mode_load = m;
        @(negedge clk);
        start = 1'b0; cmd = 8'h00; mode_load = ~m;
        check("R8 busy after start", busy, 1'b1);
        seen = 1'b0;
        for (int k = 0; k < 4000 && !seen; k++) begin
            if (mid_start && k == 60) begin
                start = 1'b1; cmd = 8'h11; mode_load = 1'b0;
            end else begin
                start = 1'b0;
            end
            if (done) seen = 1'b1;
            else @(negedge clk);
        end
        check("R8 done seen", seen, 1'b1);
        check("R6 mask", fault_mask, exp_mask);
        check("R6 pass", pass, (exp_mask == 8'h00));
        check("R7 shutdown", shutdown, (st == 8'hFF) && (c != 8'hFF));
        check("R8 busy in done cycle", busy, 1'b1);
        if (hit_done) begin
            start = 1'b1; cmd = 8'h22; mode_load = 1'b0;
        end
        @(negedge clk);
        start = 1'b0;
        check("R8 done single", done, 1'b0);
        check("R8 busy drop", busy, 1'b0);
        repeat (30) @(negedge clk);
        check("R9 no third word", words, 2);
        check("R9 cs idle", cs_n, 1'b1);
        check("R8 one done", done_cnt, 1);
        check("R2 word1", word_log[0], c);
        check("R2 word2", word_log[1], c);
        check(m ? "R4 gap min" : "R3 gap min", (meas_gap >= lim), 1'b1);
        check(m ? "R4 gap max" : "R3 gap max", (meas_gap <= lim + 4), 1'b1);
        check("R10 mask held", fault_mask, exp_mask);
        check("R10 pass held", pass, (exp_mask == 8'h00));
    endtask

    initial begin
        logic [7:0] m1;
        repeat (3) @(negedge clk);
        check("R1 cs_n", cs_n, 1'b1);
        check("R1 sclk", sclk, 1'b0);
        check("R1 busy", busy, 1'b0);
        check("R1 done", done, 1'b0);
        check("R1 pass", pass, 1'b0);
        check("R1 mask", fault_mask, 8'h00);
        check("R1 shutdown", shutdown, 1'b0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            run_seq(VEC[i][25:18], VEC[i][17], VEC[i][16:9], VEC[i][8], VEC[i][7:0], 1'b0, 1'b0);
        end

        // R5: first-word status must not matter
        run_seq(8'h96, 1'b0, 8'h24, 1'b0, 8'h00, 1'b0, 1'b0);
        m1 = fault_mask;
        run_seq(8'h96, 1'b0, 8'h24, 1'b0, 8'hFF, 1'b0, 1'b0);
        check("R5 first status ignored", fault_mask, m1);

        // R9: start during the long gap, then start in the done cycle
        run_seq(8'hC3, 1'b1, 8'h10, 1'b0, 8'hAA, 1'b1, 1'b0);
        run_seq(8'h5A, 1'b0, 8'h00, 1'b0, 8'h33, 1'b0, 1'b1);

        // R10: results stay put while idle
        repeat (50) @(negedge clk);
        check("R10 idle hold mask", fault_mask, 8'h00);
        check("R10 idle hold pass", pass, 1'b1);
        check("R10 idle hold shutdown", shutdown, 1'b0);

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            tests++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule